// File: doc/BRIEF.md
# Multi-port PHY link state monitor

This block watches the link state of a small group of Ethernet PHY ports and keeps one link-alive flag per port. Each scan runs on a start pulse or on a periodic tick. It visits the ports mapped to the selected MAC unit in ascending order and reads PHY management registers through a simple request/response port. That port stands in for a serial management master that lives outside the block. A port already known to be alive costs one read. A port known to be dead is checked in steps: reset completion first, then autonegotiation state, then link.

When a scan ends, the block reports how many ports of the unit have link. While the scan runs, it gives a one-cycle pulse for every link gained and for every link lost. For the WAN unit, the block then resolves speed and duplex from the first live port. It re-reads that port's specific status until the resolved bit comes up, and stops after a bounded number of reads. The LAN unit reports fixed values and reads no PHY for this step.

The request side is valid/ready. `rd_req_valid` stays high with a stable address and register number until `rd_req_ready` is sampled high. Only one read is ever outstanding. The response side has no back-pressure: the block waits for `rd_rsp_valid` and always takes the word in the cycle it is presented.

Top module: `lsm_link_monitor`

## Requirements
- R1: After reset, `busy`, `alive`, `link_count`, `full_duplex`, `speed_unknown` and all pulses are 0, `speed` is 0 (10 Mb/s), and no read is requested.
- R2: While idle, a high `scan_start` or `scan_tick` starts a scan of the unit given by `unit_sel` at that edge (0 = LAN, ports 0 to 3; 1 = WAN, port 4). Reads go only to those ports, and the PHY address equals the port index.
- R3: For a port flagged alive, the block reads only register 17. If bit 10 (link pass) is 0, the port's flag clears and `link_lost` pulses once. Otherwise the port is counted as linked.
- R4: For a port flagged dead, the block first reads register 1. If bit 15 of that word is 1 (reset not yet complete), the port gets no further reads in this scan.
- R5: When reset is complete, the block reads register 0. It reads register 17 only when register 0 bit 12 (autonegotiation enable) is 0 or register 1 bit 5 (autonegotiation done) is 1. If register 17 bit 10 is then 1, the port's flag sets and `link_gained` pulses once.
- R6: At the end of a scan, `scan_done` pulses once. In that cycle `link_count` equals the number of alive ports of the scanned unit.
- R7: For the WAN unit, the first alive port is re-read at register 17 until bit 11 (resolved) is 1. The block gives up after RESOLVE_MAX reads and decodes the last word.
- R8: Speed comes from register 17 bits 15:14: 0 = 10, 1 = 100, 2 = 1000 Mb/s, reported on `speed` with the same code. Duplex comes from bit 13. Code 3 sets `speed_unknown`, and the block moves on to the next alive port. With no live port that decodes, the result is 10 Mb/s, half duplex.
- R9: For the LAN unit, the result is 100 Mb/s, full duplex, with no resolve reads.
- R10: A trigger that arrives while a scan runs is ignored. It starts no second scan, and the unit is latched only at the start.
- R11: A request holds `rd_req_valid`, `rd_req_phy` and `rd_req_reg` steady until accepted. No new request is raised before the previous response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_sel | input | 1 | MAC unit to scan: 0 LAN, 1 WAN |
| scan_start | input | 1 | Scan request pulse |
| scan_tick | input | 1 | Periodic scan request |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_phy | output | 5 | PHY address of the read |
| rd_req_reg | output | 5 | Register number of the read |
| rd_rsp_valid | input | 1 | Read data valid (always accepted) |
| rd_rsp_data | input | 16 | Read data |
| busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle end-of-scan pulse |
| link_count | output | 3 | Linked ports of the scanned unit |
| alive | output | 5 | Per-port link-alive flags |
| link_gained | output | 1 | Pulse per port that gained link |
| link_lost | output | 1 | Pulse per port that lost link |
| speed | output | 2 | Resolved speed code |
| full_duplex | output | 1 | Resolved duplex |
| speed_unknown | output | 1 | An undecodable speed code was seen |

## Verification
The bench keeps the default five ports with port 4 as the WAN port and sets RESOLVE_MAX to 6. With that limit, a WAN port whose resolved bit never rises exhausts the retry bound in a few dozen cycles, so the read count at the limit can be checked exactly. The PHY model stalls the ready signal and the response at random, so requests are held at random points. Extra triggers are injected mid-scan to show that they are dropped.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] REG_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] REG_BSTAT = 5'd1;
  localparam logic [ADDR_W-1:0] REG_PSTAT = 5'd17;

  localparam int B_AN_DONE  = 5;
  localparam int B_RST_BUSY = 15;
  localparam int B_AN_EN    = 12;
  localparam int B_LINK     = 10;
  localparam int B_RESOLVED = 11;
  localparam int B_FDX      = 13;
  localparam int B_SPD_LO   = 14;

  typedef enum logic [1:0] {
    SPD_10   = 2'd0,
    SPD_100  = 2'd1,
    SPD_1000 = 2'd2,
    SPD_BAD  = 2'd3
  } spd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PICK, S_REQ, S_WAIT, S_RPICK, S_DONE
  } st_e;

  typedef enum logic [2:0] {
    K_LIVE, K_BSTAT, K_CTRL, K_PSTAT, K_RESOLVE
  } step_e;

  typedef struct packed {
    logic       link;
    logic       resolved;
    logic       fdx;
    logic [1:0] speed;
    logic       an_done;
    logic       rst_busy;
    logic       an_en;
  } fields_t;
endpackage

// File: rtl/lsm_next_port.sv
module lsm_next_port #(
  parameter int N  = 5,
  parameter int PW = 3
) (
  input  logic [N-1:0]  mask,
  output logic          found,
  output logic [PW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/lsm_field_decode.sv
module lsm_field_decode
  import lsm_pkg::*;
(
  input  logic [DATA_W-1:0] word,
  output fields_t           f
);
  logic unused_bits;
  assign unused_bits = ^{word[9:6], word[4:0]};

  always_comb begin
    f.link     = word[B_LINK];
    f.resolved = word[B_RESOLVED];
    f.fdx      = word[B_FDX];
    f.speed    = word[B_SPD_LO +: 2];
    f.an_done  = word[B_AN_DONE];
    f.rst_busy = word[B_RST_BUSY];
    f.an_en    = word[B_AN_EN];
  end
endmodule

// File: rtl/lsm_link_monitor.sv
module lsm_link_monitor
  import lsm_pkg::*;
#(
  parameter int               NPORT       = 5,
  parameter logic [NPORT-1:0] WAN_MAP     = {1'b1, {(NPORT-1){1'b0}}},
  parameter int               RESOLVE_MAX = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_sel,
  input  logic              scan_start,
  input  logic              scan_tick,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [4:0]        rd_req_phy,
  output logic [4:0]        rd_req_reg,
  input  logic              rd_rsp_valid,
  input  logic [15:0]       rd_rsp_data,
  output logic              busy,
  output logic              scan_done,
  output logic [2:0]        link_count,
  output logic [NPORT-1:0]  alive,
  output logic              link_gained,
  output logic              link_lost,
  output logic [1:0]        speed,
  output logic              full_duplex,
  output logic              speed_unknown
);
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int CW = $clog2(NPORT + 1);
  localparam int TW = $clog2(RESOLVE_MAX + 1);

  st_e              state;
  step_e            step;
  logic [PW-1:0]    cur;
  logic [NPORT-1:0] rem;
  logic [NPORT-1:0] alive_q;
  logic             unit_q;
  logic [CW-1:0]    cnt;
  logic [TW-1:0]    tries;
  logic             an_done_q;
  spd_e             spd_w;
  logic             fdx_w;
  logic             unk_w;
  logic [CW-1:0]    count_q;
  spd_e             speed_q;
  logic             fdx_q;
  logic             unk_q;
  logic             done_q;
  logic             gained_q;
  logic             lost_q;

  logic [NPORT-1:0] unit_mask;
  logic             nx_found;
  logic [PW-1:0]    nx_idx;
  fields_t          fld;
  logic [TW-1:0]    tries_nx;

  assign unit_mask = unit_q ? WAN_MAP : ~WAN_MAP;
  assign tries_nx  = tries + TW'(1);

  lsm_next_port #(.N(NPORT), .PW(PW)) u_pick (
    .mask  (rem),
    .found (nx_found),
    .idx   (nx_idx)
  );

  lsm_field_decode u_dec (
    .word (rd_rsp_data),
    .f    (fld)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      step      <= K_LIVE;
      cur       <= '0;
      rem       <= '0;
      alive_q   <= '0;
      unit_q    <= 1'b0;
      cnt       <= '0;
      tries     <= '0;
      an_done_q <= 1'b0;
      spd_w     <= SPD_10;
      fdx_w     <= 1'b0;
      unk_w     <= 1'b0;
      count_q   <= '0;
      speed_q   <= SPD_10;
      fdx_q     <= 1'b0;
      unk_q     <= 1'b0;
      done_q    <= 1'b0;
      gained_q  <= 1'b0;
      lost_q    <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      gained_q <= 1'b0;
      lost_q   <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (scan_start || scan_tick) begin
            unit_q <= unit_sel;
            rem    <= unit_sel ? WAN_MAP : ~WAN_MAP;
            cnt    <= '0;
            spd_w  <= SPD_10;
            fdx_w  <= 1'b0;
            unk_w  <= 1'b0;
            state  <= S_PICK;
          end
        end
        S_PICK: begin
          if (nx_found) begin
            cur         <= nx_idx;
            rem[nx_idx] <= 1'b0;
            step        <= alive_q[nx_idx] ? K_LIVE : K_BSTAT;
            state       <= S_REQ;
          end else if (unit_q) begin
            rem   <= alive_q & unit_mask;
            state <= S_RPICK;
          end else begin
            spd_w <= SPD_100;
            fdx_w <= 1'b1;
            state <= S_DONE;
          end
        end
        S_RPICK: begin
          if (nx_found) begin
            cur         <= nx_idx;
            rem[nx_idx] <= 1'b0;
            step        <= K_RESOLVE;
            tries       <= '0;
            state       <= S_REQ;
          end else begin
            state <= S_DONE;
          end
        end
        S_REQ: begin
          if (rd_req_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (rd_rsp_valid) begin
            unique case (step)
              K_LIVE: begin
                if (fld.link) begin
                  cnt <= cnt + CW'(1);
                end else begin
                  alive_q[cur] <= 1'b0;
                  lost_q       <= 1'b1;
                end
                state <= S_PICK;
              end
              K_BSTAT: begin
                an_done_q <= fld.an_done;
                if (fld.rst_busy) begin
                  state <= S_PICK;
                end else begin
                  step  <= K_CTRL;
                  state <= S_REQ;
                end
              end
              K_CTRL: begin
                if (!fld.an_en || an_done_q) begin
                  step  <= K_PSTAT;
                  state <= S_REQ;
                end else begin
                  state <= S_PICK;
                end
              end
              K_PSTAT: begin
                if (fld.link) begin
                  alive_q[cur] <= 1'b1;
                  gained_q     <= 1'b1;
                  cnt          <= cnt + CW'(1);
                end
                state <= S_PICK;
              end
              default: begin
                if (fld.resolved || (tries_nx == TW'(RESOLVE_MAX))) begin
                  if (fld.speed == SPD_BAD) begin
                    unk_w <= 1'b1;
                    state <= S_RPICK;
                  end else begin
                    spd_w <= spd_e'(fld.speed);
                    fdx_w <= fld.fdx;
                    state <= S_DONE;
                  end
                end else begin
                  tries <= tries_nx;
                  state <= S_REQ;
                end
              end
            endcase
          end
        end
        S_DONE: begin
          done_q  <= 1'b1;
          count_q <= cnt;
          speed_q <= spd_w;
          fdx_q   <= fdx_w;
          unk_q   <= unk_w;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (step)
      K_BSTAT: rd_req_reg = REG_BSTAT;
      K_CTRL:  rd_req_reg = REG_CTRL;
      default: rd_req_reg = REG_PSTAT;
    endcase
  end

  assign rd_req_valid  = (state == S_REQ);
  assign rd_req_phy    = ADDR_W'(cur);
  assign busy          = (state != S_IDLE);
  assign scan_done     = done_q;
  assign link_count    = 3'(count_q);
  assign alive         = alive_q;
  assign link_gained   = gained_q;
  assign link_lost     = lost_q;
  assign speed         = speed_q;
  assign full_duplex   = fdx_q;
  assign speed_unknown = unk_q;
endmodule

// File: rtl/lsm_link_monitor_chk.sv
module lsm_link_monitor_chk #(
  parameter int               NPORT   = 5,
  parameter logic [NPORT-1:0] WAN_MAP = {1'b1, {(NPORT-1){1'b0}}}
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_start,
  input logic             scan_tick,
  input logic             busy,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic [4:0]       rd_req_phy,
  input logic [4:0]       rd_req_reg,
  input logic             scan_done,
  input logic [2:0]       link_count,
  input logic [NPORT-1:0] alive,
  input logic             link_lost,
  input logic             unit_q
);
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [NPORT-1:0] mask;
  logic             in_unit;
  assign mask = unit_q ? WAN_MAP : ~WAN_MAP;
  always_comb in_unit = (int'(rd_req_phy) < NPORT) && mask[rd_req_phy[PW-1:0]];

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_phy) && $stable(rd_req_reg));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid);

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(scan_start || scan_tick));

  // R2
  unit_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> in_unit);

  // R6
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> (32'(link_count) == $countones(alive & mask)));

  // R3
  lost_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_lost |-> ($countones(alive) < $countones($past(alive))));
endmodule

bind lsm_link_monitor lsm_link_monitor_chk #(.NPORT(NPORT), .WAN_MAP(WAN_MAP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scan_start   (scan_start),
  .scan_tick    (scan_tick),
  .busy         (busy),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_phy   (rd_req_phy),
  .rd_req_reg   (rd_req_reg),
  .scan_done    (scan_done),
  .link_count   (link_count),
  .alive        (alive),
  .link_lost    (link_lost),
  .unit_q       (unit_q)
);

// File: tb/lsm_link_monitor_tb.sv
module lsm_link_monitor_tb;
  localparam int CLK_NS = 10;
  localparam int NPORT  = 5;
  localparam int RMAX   = 6;
  localparam logic [NPORT-1:0] WAN = 5'b10000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        unit_sel, scan_start, scan_tick;
  logic        rd_req_valid, rd_req_ready;
  logic [4:0]  rd_req_phy, rd_req_reg;
  logic        rd_rsp_valid;
  logic [15:0] rd_rsp_data;
  logic        busy, scan_done, link_gained, link_lost, full_duplex, speed_unknown;
  logic [2:0]  link_count;
  logic [NPORT-1:0] alive;
  logic [1:0]  speed;

  lsm_link_monitor #(.NPORT(NPORT), .WAN_MAP(WAN), .RESOLVE_MAX(RMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .unit_sel(unit_sel), .scan_start(scan_start), .scan_tick(scan_tick),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_phy(rd_req_phy),
    .rd_req_reg(rd_req_reg), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .busy(busy), .scan_done(scan_done), .link_count(link_count), .alive(alive),
    .link_gained(link_gained), .link_lost(link_lost), .speed(speed),
    .full_duplex(full_duplex), .speed_unknown(speed_unknown)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // PHY model register files
  logic [15:0] bst [NPORT];
  logic [15:0] ctl [NPORT];
  logic [15:0] pst [NPORT];
  logic        cur_unit = 1'b0;

  int reads_tot = 0, bad_tot = 0, gain_tot = 0, lost_tot = 0, done_tot = 0;
  logic        pend, hold;
  int          dly;
  logic [15:0] pdata;
  logic [4:0]  hphy, hreg;

  function automatic logic [15:0] model_rd(input logic [4:0] phy, input logic [4:0] r);
    if (int'(phy) >= NPORT) return 16'hffff;
    case (r)
      5'd0:    return ctl[phy];
      5'd1:    return bst[phy];
      5'd17:   return pst[phy];
      default: return 16'hffff;
    endcase
  endfunction

  function automatic bit in_unit(input logic u, input int p);
    return u ? WAN[p] : !WAN[p];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
      rd_req_ready <= 1'b0;
      pend <= 1'b0;
      hold <= 1'b0;
      dly  <= 0;
    end else begin
      rd_rsp_valid <= 1'b0;
      rd_req_ready <= ($urandom % 4) != 0;
      // R11: a held request keeps its address and register
      if (hold) chk(rd_req_valid && rd_req_phy == hphy && rd_req_reg == hreg, "R11",
                    int'(rd_req_phy), int'(hphy));
      hold <= rd_req_valid && !rd_req_ready;
      hphy <= rd_req_phy;
      hreg <= rd_req_reg;
      if (pend) begin
        if (dly == 0) begin
          rd_rsp_valid <= 1'b1;
          rd_rsp_data  <= pdata;
          pend <= 1'b0;
        end else dly <= dly - 1;
      end
      if (rd_req_valid && rd_req_ready) begin
        pend  <= 1'b1;
        dly   <= int'($urandom % 3);
        pdata <= model_rd(rd_req_phy, rd_req_reg);
        reads_tot++;
        if (int'(rd_req_phy) >= NPORT || !in_unit(cur_unit, int'(rd_req_phy))) bad_tot++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (link_gained) gain_tot++;
      if (link_lost)   lost_tot++;
      if (scan_done)   done_tot++;
    end
  end

  // bench reference state
  logic [NPORT-1:0] alive_m;
  logic [NPORT-1:0] e_alive;
  int e_cnt, e_gain, e_lost, e_reads, e_spd, e_fdx, e_unk;

  task automatic expect_scan(input logic u);
    bit picked;
    e_alive = alive_m; e_cnt = 0; e_gain = 0; e_lost = 0; e_reads = 0;
    for (int p = 0; p < NPORT; p++) begin
      if (in_unit(u, p)) begin
        e_reads++;
        if (alive_m[p]) begin
          if (pst[p][10]) e_cnt++;
          else begin e_alive[p] = 1'b0; e_lost++; end
        end else if (!bst[p][15]) begin
          e_reads++;
          if (!ctl[p][12] || bst[p][5]) begin
            e_reads++;
            if (pst[p][10]) begin e_alive[p] = 1'b1; e_cnt++; e_gain++; end
          end
        end
      end
    end
    e_spd = 0; e_fdx = 0; e_unk = 0;
    if (!u) begin
      e_spd = 1; e_fdx = 1;
    end else begin
      picked = 1'b0;
      for (int p = 0; p < NPORT; p++) begin
        if (!picked && in_unit(u, p) && e_alive[p]) begin
          e_reads += pst[p][11] ? 1 : RMAX;
          if (pst[p][15:14] == 2'd3) e_unk = 1;
          else begin e_spd = int'(pst[p][15:14]); e_fdx = int'(pst[p][13]); picked = 1'b1; end
        end
      end
    end
  endtask

  function automatic logic [15:0] mk_pst(input logic [1:0] s, input logic f,
                                         input logic res, input logic lnk);
    return {s, f, 1'b0, res, lnk, 10'b0};
  endfunction

  task automatic set_port(input int p, input logic [15:0] b, input logic [15:0] c, input logic [15:0] s);
    bst[p] = b; ctl[p] = c; pst[p] = s;
  endtask

  task automatic do_scan(input logic u, input bit via_tick, input bit poke);
    int r0, b0, g0, l0, d0, n;
    expect_scan(u);
    r0 = reads_tot; b0 = bad_tot; g0 = gain_tot; l0 = lost_tot; d0 = done_tot;
    @(negedge clk);
    cur_unit = u;
    unit_sel = u;
    if (via_tick) scan_tick = 1'b1; else scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0; scan_tick = 1'b0; unit_sel = ~u;
    if (poke) begin
      @(negedge clk); scan_start = 1'b1; scan_tick = 1'b1;
      @(negedge clk); scan_start = 1'b0; scan_tick = 1'b0;
    end
    n = 0;
    while (done_tot == d0 && n < 3000) begin @(negedge clk); #1; n++; end
    if (n >= 3000) chk(1'b0, "R6 watchdog", 0, 1);
    repeat (5) @(negedge clk);
    #1;
    chk(done_tot - d0 == 1, "R10", done_tot - d0, 1);
    chk(busy == 1'b0, "R10", int'(busy), 0);
    chk(bad_tot == b0, "R2", bad_tot - b0, 0);
    chk(int'(link_count) == e_cnt, "R6", int'(link_count), e_cnt);
    chk(alive == e_alive, "R5", int'(alive), int'(e_alive));
    chk(gain_tot - g0 == e_gain, "R5", gain_tot - g0, e_gain);
    chk(lost_tot - l0 == e_lost, "R3", lost_tot - l0, e_lost);
    chk(reads_tot - r0 == e_reads, "R4/R7", reads_tot - r0, e_reads);
    chk(int'(speed) == e_spd, u ? "R8" : "R9", int'(speed), e_spd);
    chk(int'(full_duplex) == e_fdx, u ? "R8" : "R9", int'(full_duplex), e_fdx);
    chk(int'(speed_unknown) == e_unk, "R8", int'(speed_unknown), e_unk);
    alive_m = e_alive;
  endtask

  initial begin
    #(CLK_NS * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0013));
    rst_n = 1'b0; unit_sel = 1'b0; scan_start = 1'b0; scan_tick = 1'b0;
    alive_m = '0;
    for (int p = 0; p < NPORT; p++) set_port(p, 16'h0020, 16'h1000, mk_pst(2'd1, 1'b1, 1'b1, 1'b1));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && alive == '0 && link_count == 3'd0, "R1", int'(alive), 0);
    chk(speed == 2'd0 && !full_duplex && !speed_unknown, "R1", int'(speed), 0);
    chk(!rd_req_valid && !scan_done && !link_gained && !link_lost, "R1", int'(rd_req_valid), 0);
    rst_n = 1'b1;

    // LAN: all four ports come up, fixed 100/full (R5, R9)
    do_scan(1'b0, 1'b0, 1'b0);
    // WAN: reset still pending, skip after one read (R4)
    set_port(4, 16'h8020, 16'h1000, mk_pst(2'd2, 1'b1, 1'b1, 1'b1));
    do_scan(1'b1, 1'b1, 1'b0);
    // WAN: autoneg enabled but not done, stop after control read (R5)
    set_port(4, 16'h0000, 16'h1000, mk_pst(2'd2, 1'b1, 1'b1, 1'b1));
    do_scan(1'b1, 1'b0, 1'b0);
    // WAN: autoneg disabled, link up, never resolves: timeout at RMAX (R7)
    set_port(4, 16'h0000, 16'h0000, mk_pst(2'd2, 1'b0, 1'b0, 1'b1));
    do_scan(1'b1, 1'b0, 1'b0);
    // WAN: alive with undecodable speed (R8)
    set_port(4, 16'h0020, 16'h1000, mk_pst(2'd3, 1'b1, 1'b1, 1'b1));
    do_scan(1'b1, 1'b1, 1'b0);
    // WAN: link lost (R3)
    set_port(4, 16'h0020, 16'h1000, mk_pst(2'd1, 1'b1, 1'b1, 1'b0));
    do_scan(1'b1, 1'b0, 1'b0);
    // LAN: two ports drop, extra triggers mid-scan (R3, R10)
    pst[1][10] = 1'b0; pst[3][10] = 1'b0;
    do_scan(1'b0, 1'b0, 1'b1);

    for (int it = 0; it < 40; it++) begin
      for (int p = 0; p < NPORT; p++) begin
        set_port(p,
          {($urandom % 4) == 0, 9'b0, 1'($urandom), 5'b0},
          {3'b0, 1'($urandom), 12'b0},
          mk_pst(2'($urandom), 1'($urandom), ($urandom % 4) != 0, ($urandom % 3) != 0));
      end
      do_scan(1'($urandom), 1'($urandom), ($urandom % 5) == 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule